// File: doc/BRIEF.md
# Segmented Current-Steering DAC Code Decoder (I/Q pair)

This block turns a binary DAC code into the switch controls of a two-level segmented current-steering array. The code splits into three fields. The upper field selects how many of fifteen coarse unit sources are on. The middle field selects how many of fifteen fine unit sources are on, each worth one sixteenth of a coarse unit. The lowest bits pass straight through as binary-weighted controls.

Two identical decoders, one for the I channel and one for the Q channel, share a single control path. All of their controls are registered, so both arrays switch together on the same rising clock edge. Every source has a complementary pair of controls: an A control steers it to the A output node and a B control steers it to the B output node, so the total steered current never changes. A sleep input parks both arrays in a fixed idle state with every source on the B node.

Top module: `segdec_top`

## Requirements
- R1: The 10-bit code is split as coarse field = bits [9:6], fine field = bits [5:2], binary field = bits [1:0].
- R2: Coarse A line k (k = 0..14) is 1 exactly when the coarse field is greater than k.
- R3: Fine A line k (k = 0..14) is 1 exactly when the fine field is greater than k.
- R4: Binary A control bit 1 equals code bit 1 (weight 2) and bit 0 equals code bit 0 (weight 1).
- R5: Every B control is the inverse of its matching A control at all times after reset.
- R6: Controls are registered: a code presented before a rising edge appears on the outputs after that edge, one cycle of latency, and holds until the next edge.
- R7: The I and Q decoders update on the same edge; equal codes give equal controls, and each channel decodes only its own code.
- R8: While sleepIn is 1 at a rising edge, after that edge every A control is 0 and every B control is 1, whatever the codes; after sleepIn returns to 0, the next edge restores decoding.
- R9: While rstN is 0, every A control is 0 and every B control is 1.
- R10: The weighted sum of the A controls (coarse lines x64, fine lines x4, binary bits x2 and x1) equals the code registered on the previous edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Update clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepIn | input | 1 | Forces the idle state on both arrays |
| codeI | input | 10 | I channel DAC code |
| codeQ | input | 10 | Q channel DAC code |
| iMsbA | output | 15 | I coarse thermometer, A side |
| iMsbB | output | 15 | I coarse thermometer, B side |
| iMidA | output | 15 | I fine thermometer, A side |
| iMidB | output | 15 | I fine thermometer, B side |
| iLsbA | output | 2 | I binary controls, A side |
| iLsbB | output | 2 | I binary controls, B side |
| qMsbA | output | 15 | Q coarse thermometer, A side |
| qMsbB | output | 15 | Q coarse thermometer, B side |
| qMidA | output | 15 | Q fine thermometer, A side |
| qMidB | output | 15 | Q fine thermometer, B side |
| qLsbA | output | 2 | Q binary controls, A side |
| qLsbB | output | 2 | Q binary controls, B side |

## Verification
The decoders are driven with a full sweep of all 1024 codes on I while Q runs the reversed sweep, so every thermometer length in both segments and every binary pattern is seen, and a swapped or shared channel path shows up as a mismatch. Field boundary codes (0, 1023, 63, 64, 3, 4, 60) separate an off-by-one in the thermometer compare from a wrong field split. A sleep pattern applied with non-zero codes tells whether idle really overrides the codes and whether decoding resumes after one edge, and a hold test with changing inputs between edges exposes any unregistered path.

// File: rtl/segdec_pkg.sv
package segdec_pkg;
  localparam int DEF_SEG_W = 4;
  localparam int DEF_LSB_W = 2;

  typedef struct packed {
    logic load;
    logic idle;
  } ctrlStrobes_t;
endpackage

// File: rtl/segdec_ctrl.sv
module segdec_ctrl
  import segdec_pkg::*;
(
  input  logic         sleepIn,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.idle = sleepIn;
    strobes.load = ~sleepIn;
  end
endmodule

// File: rtl/segdec_datapath.sv
module segdec_datapath
  import segdec_pkg::*;
#(
  parameter int SEG_W = DEF_SEG_W,
  parameter int LSB_W = DEF_LSB_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobes_t              strobes,
  input  logic [2*SEG_W+LSB_W-1:0]  code,
  output logic [(1<<SEG_W)-2:0]     msbA,
  output logic [(1<<SEG_W)-2:0]     msbB,
  output logic [(1<<SEG_W)-2:0]     midA,
  output logic [(1<<SEG_W)-2:0]     midB,
  output logic [LSB_W-1:0]          lsbA,
  output logic [LSB_W-1:0]          lsbB
);
  localparam int CODE_W  = 2*SEG_W + LSB_W;
  localparam int UNITS   = (1 << SEG_W) - 1;
  localparam int MID_WT  = 1 << LSB_W;
  localparam int MSB_WT  = 1 << (SEG_W + LSB_W);

  logic [SEG_W-1:0] msbField, midField;
  logic [LSB_W-1:0] lsbField;
  logic [UNITS-1:0] msbNext, midNext;

  // R1 field split
  assign msbField = code[CODE_W-1 -: SEG_W];
  assign midField = code[LSB_W +: SEG_W];
  assign lsbField = code[LSB_W-1:0];

  // R2 R3 thermometer decode per segment
  for (genvar k = 0; k < UNITS; k++) begin : g_therm
    assign msbNext[k] = (msbField > SEG_W'(k));
    assign midNext[k] = (midField > SEG_W'(k));
  end

  // A-side registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msbA <= '0;
      midA <= '0;
      lsbA <= '0;
    end else if (strobes.idle) begin
      msbA <= '0;
      midA <= '0;
      lsbA <= '0;
    end else if (strobes.load) begin
      msbA <= msbNext;
      midA <= midNext;
      lsbA <= lsbField;
    end
  end

  // B-side registers, loaded independently with the complement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msbB <= '1;
      midB <= '1;
      lsbB <= '1;
    end else if (strobes.idle) begin
      msbB <= '1;
      midB <= '1;
      lsbB <= '1;
    end else if (strobes.load) begin
      msbB <= ~msbNext;
      midB <= ~midNext;
      lsbB <= ~lsbField;
    end
  end

  int sumA;
  always_comb sumA = $countones(msbA) * MSB_WT + $countones(midA) * MID_WT + int'(lsbA);

  // R5
  ab_complement_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msbB == ~msbA) && (midB == ~midA) && (lsbB == ~lsbA))
    else $error("A/B controls not complementary");

  // R8
  sleep_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.idle |=> (msbA == '0) && (midA == '0) && (lsbA == '0))
    else $error("idle state not reached");

  // R2
  msb_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> $countones(msbA) == int'($past(msbField)))
    else $error("coarse line count wrong");

  // R3
  mid_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> $countones(midA) == int'($past(midField)))
    else $error("fine line count wrong");

  // R10
  weight_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> sumA == int'($past(code)))
    else $error("weighted sum differs from code");
endmodule

// File: rtl/segdec_top.sv
module segdec_top
  import segdec_pkg::*;
#(
  parameter int SEG_W = DEF_SEG_W,
  parameter int LSB_W = DEF_LSB_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sleepIn,
  input  logic [2*SEG_W+LSB_W-1:0]  codeI,
  input  logic [2*SEG_W+LSB_W-1:0]  codeQ,
  output logic [(1<<SEG_W)-2:0]     iMsbA,
  output logic [(1<<SEG_W)-2:0]     iMsbB,
  output logic [(1<<SEG_W)-2:0]     iMidA,
  output logic [(1<<SEG_W)-2:0]     iMidB,
  output logic [LSB_W-1:0]          iLsbA,
  output logic [LSB_W-1:0]          iLsbB,
  output logic [(1<<SEG_W)-2:0]     qMsbA,
  output logic [(1<<SEG_W)-2:0]     qMsbB,
  output logic [(1<<SEG_W)-2:0]     qMidA,
  output logic [(1<<SEG_W)-2:0]     qMidB,
  output logic [LSB_W-1:0]          qLsbA,
  output logic [LSB_W-1:0]          qLsbB
);
  ctrlStrobes_t strobes;

  segdec_ctrl ctrl_i (
    .sleepIn (sleepIn),
    .strobes (strobes)
  );

  segdec_datapath #(.SEG_W(SEG_W), .LSB_W(LSB_W)) chanI_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .code(codeI),
    .msbA(iMsbA), .msbB(iMsbB), .midA(iMidA), .midB(iMidB),
    .lsbA(iLsbA), .lsbB(iLsbB)
  );

  segdec_datapath #(.SEG_W(SEG_W), .LSB_W(LSB_W)) chanQ_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .code(codeQ),
    .msbA(qMsbA), .msbB(qMsbB), .midA(qMidA), .midB(qMidB),
    .lsbA(qLsbA), .lsbB(qLsbB)
  );

  // R7
  iq_lockstep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (codeI == codeQ) |=> (iMsbA == qMsbA) && (iMidA == qMidA) && (iLsbA == qLsbA))
    else $error("I and Q decoders out of step");
endmodule

// File: tb/segdec_top_tb_top.sv
module segdec_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepIn = 1'b0;
  logic [9:0] codeI = '0, codeQ = '0;
  logic [14:0] iMsbA, iMsbB, iMidA, iMidB, qMsbA, qMsbB, qMidA, qMidB;
  logic [1:0]  iLsbA, iLsbB, qLsbA, qLsbB;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  segdec_top dut_i (
    .clk(clk), .rstN(rstN), .sleepIn(sleepIn), .codeI(codeI), .codeQ(codeQ),
    .iMsbA(iMsbA), .iMsbB(iMsbB), .iMidA(iMidA), .iMidB(iMidB),
    .iLsbA(iLsbA), .iLsbB(iLsbB),
    .qMsbA(qMsbA), .qMsbB(qMsbB), .qMidA(qMidA), .qMidB(qMidB),
    .qLsbA(qLsbA), .qLsbB(qLsbB)
  );

  // expected A controls as {coarse[14:0], fine[14:0], binary[1:0]}
  function automatic logic [31:0] expA(input logic [9:0] c);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < 15; k++) begin
      r[17 + k] = (int'(c[9:6]) > k);
      r[2 + k]  = (int'(c[5:2]) > k);
    end
    r[1:0] = c[1:0];
    return r;
  endfunction

  task automatic checkChan(input string req, input bit isQ, input logic [31:0] wantA);
    logic [31:0] gotA, gotB;
    gotA = isQ ? {qMsbA, qMidA, qLsbA} : {iMsbA, iMidA, iLsbA};
    gotB = isQ ? {qMsbB, qMidB, qLsbB} : {iMsbB, iMidB, iLsbB};
    checks++;
    if (gotA !== wantA || gotB !== ~wantA) begin
      errors++;
      $display("FAIL %s ch=%s A=%h B=%h expected A=%h B=%h", req, isQ ? "Q" : "I",
               gotA, gotB, wantA, ~wantA);
    end
  endtask

  task automatic applyAndCheck(input string req, input logic [9:0] ci, input logic [9:0] cq);
    @(negedge clk);
    codeI = ci; codeQ = cq;
    @(negedge clk);
    checkChan(req, 1'b0, expA(ci));
    checkChan(req, 1'b1, expA(cq));
  endtask

  // R9 reset state
  task automatic testReset();
    codeI = 10'h2AB; codeQ = 10'h155;
    repeat (2) @(negedge clk);
    checkChan("R9", 1'b0, 32'h0);
    checkChan("R9", 1'b1, 32'h0);
    rstN = 1'b1;
  endtask

  // R2 R3 R4 R10 boundaries
  task automatic testBoundaries();
    applyAndCheck("R2 R3 R4 zero", 10'd0, 10'd1023);
    applyAndCheck("R1 R3 field edge", 10'd63, 10'd64);
    applyAndCheck("R3 R4 fine edge", 10'd3, 10'd4);
    applyAndCheck("R2 R3 top of fine", 10'd60, 10'd960);
  endtask

  // R1 R2 R3 R4 R5 R7 R10 full sweep
  task automatic testSweep();
    for (int c = 0; c < 1024; c++)
      applyAndCheck("R10 sweep", 10'(c), 10'(1023 - c));
    applyAndCheck("R7 equal codes", 10'h1C7, 10'h1C7);
  endtask

  // R6 hold between edges
  task automatic testHold();
    @(negedge clk);
    codeI = 10'h3A5; codeQ = 10'h05A;
    @(negedge clk);
    codeI = 10'h000; codeQ = 10'h3FF;
    #5;
    checkChan("R6 hold", 1'b0, expA(10'h3A5));
    checkChan("R6 hold", 1'b1, expA(10'h05A));
    @(negedge clk);
    checkChan("R6 next edge", 1'b0, expA(10'h000));
    checkChan("R6 next edge", 1'b1, expA(10'h3FF));
  endtask

  // R8 sleep override and resume
  task automatic testSleep();
    @(negedge clk);
    codeI = 10'h3FF; codeQ = 10'h2D3; sleepIn = 1'b1;
    @(negedge clk);
    checkChan("R8 sleep", 1'b0, 32'h0);
    checkChan("R8 sleep", 1'b1, 32'h0);
    codeI = 10'h111;
    @(negedge clk);
    checkChan("R8 sleep ignores code", 1'b0, 32'h0);
    sleepIn = 1'b0;
    @(negedge clk);
    checkChan("R8 resume", 1'b0, expA(10'h111));
    checkChan("R8 resume", 1'b1, expA(10'h2D3));
  endtask

  initial begin
    testReset();
    testBoundaries();
    testSweep();
    testHold();
    testSleep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule